// File: doc/BRIEF.md
# Vicinity Tag Response Frame Encoder

This block turns a short run of bytes into the one-bit modulation stream that a vicinity card sends back to a reader on a single subcarrier. Time is counted in ticks, where one tick is one subcarrier period, and the block advances by one tick on every clock. The unit of the line code is a chip of eight ticks. A modulated chip is eight ticks of 1 and an unmodulated chip is eight ticks of 0. Each data bit is split into two chips of opposite value. The data is framed by fixed eight-chip start and end patterns.

A frame begins with a one-cycle start strobe. With the strobe the block captures the byte count, the start timestamp and the rate select. It then waits until the free-running tick counter reaches the timestamp with its low three bits cleared. From there it plays the frame delayed by the timestamp's low three bits, so the frame can begin at any tick. In low-rate mode every chip lasts four times as long. Bytes arrive through a valid/ready stream into a one-byte holding register, fetched well ahead of use. After the last chip the block finishes the current eight-tick group with zeros.

Top module: `tag_resp_encoder`

## Requirements
- R1: While reset is asserted and right after it, `mod_o`, `busy_o`, `done_o` and `byte_ready_o` are all 0.
- R2: Every chip drives `mod_o` with one value for a whole chip period: 1 for a modulated chip, 0 for an unmodulated chip. A chip period is 8 ticks at the high rate.
- R3: A frame opens with the chips 0,0,0,1,1,1,0,1 and closes with the chips 1,0,1,1,1,0,0,0, each listed earliest first.
- R4: Each data bit becomes two chips: a 1 is sent as unmodulated then modulated (0,1), and a 0 as modulated then unmodulated (1,0). Bits go out least significant first, and bytes go out in stream order.
- R5: When `slow_i` is 1 at the start strobe, every chip lasts 32 ticks instead of 8.
- R6: Let B be `start_time_i` with bits [2:0] cleared and D be `start_time_i[2:0]`. The first frame tick appears on `mod_o` in the cycle where `tick_i` equals B+2+D. `mod_o` is 0 from B+2 until then.
- R7: The output window that starts at B+2 lasts L+8 ticks, where L is the frame length in ticks. `mod_o` is 0 for every window tick after the last closing chip.
- R8: `busy_o` is 1 from the cycle after an accepted strobe through the last window tick. `done_o` is 1 for exactly that last tick. `mod_o` is 0 whenever `busy_o` is 0.
- R9: A start strobe while `busy_o` is 1 is ignored, and the frame in flight continues unchanged.
- R10: A byte count of 0 sends the opening pattern followed directly by the closing pattern.
- R11: `byte_ready_o` is 1 only while busy. One byte is taken per cycle with `byte_valid_i` and `byte_ready_o` both 1, and exactly the captured count of bytes is taken per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle frame start strobe |
| frame_len_i | input | LEN_W | Number of data bytes, captured on the strobe |
| start_time_i | input | TS_W | Requested start tick, captured on the strobe |
| slow_i | input | 1 | 1 selects the low rate, captured on the strobe |
| tick_i | input | TS_W | Free-running tick counter |
| byte_i | input | 8 | Data byte |
| byte_valid_i | input | 1 | `byte_i` holds a byte |
| byte_ready_o | output | 1 | The block takes `byte_i` this cycle if valid |
| mod_o | output | 1 | Modulation enable, one value per tick |
| busy_o | output | 1 | A frame is pending or being sent |
| done_o | output | 1 | Last tick of the frame window |

## Verification
Every output has a fixed delay from the tick counter. The chip chosen in the cycle where `tick_i` is B+1+j appears on `mod_o` one cycle later, after the sequencer, the alignment tap and the output register. `busy_o` rises one cycle after the accepted strobe. The bench builds the expected tick list when the strobe is accepted and compares `mod_o`, `busy_o`, `done_o` and the ready rule at the falling edge of every clock, using that fixed offset from `tick_i`. It checks the byte count once the window has closed.

// File: rtl/tre_pkg.sv
package tre_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SEND,
    ST_FLUSH,
    ST_DONE
  } tre_state_e;

  typedef enum logic [1:0] {
    SEG_OPEN,
    SEG_DATA,
    SEG_CLOSE
  } tre_seg_e;

  // chip k of each pattern sits at bit k
  localparam logic [7:0] OPEN_CHIPS  = 8'hB8;
  localparam logic [7:0] CLOSE_CHIPS = 8'h1D;
  localparam int unsigned GRP_W      = 3;   // ticks per chip = 2**GRP_W
endpackage

// File: rtl/tre_chip_gen.sv
module tre_chip_gen
  import tre_pkg::*;
(
  input  tre_seg_e   seg_i,
  input  logic [3:0] chip_idx_i,
  input  logic [7:0] cur_byte_i,
  output logic       chip_o
);
  logic data_bit;

  always_comb begin
    data_bit = cur_byte_i[chip_idx_i[3:1]];
    unique case (seg_i)
      SEG_OPEN:  chip_o = OPEN_CHIPS[chip_idx_i[2:0]];
      SEG_DATA:  chip_o = chip_idx_i[0] ? data_bit : ~data_bit;
      SEG_CLOSE: chip_o = CLOSE_CHIPS[chip_idx_i[2:0]];
      default:   chip_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/tre_delay.sv
module tre_delay #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             din_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             dout_o
);
  localparam int unsigned NTAP = (1 << SEL_W) - 1;

  logic [NTAP-1:0] hist_q, hist_d;

  always_comb begin
    hist_d = hist_q;
    if (clr_i)     hist_d = '0;
    else if (en_i) hist_d = {hist_q[NTAP-2:0], din_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  always_comb begin
    if (sel_i == '0) dout_o = din_i;
    else             dout_o = hist_q[sel_i - 1'b1];
  end

  // R6: the alignment history starts empty so the leading ticks are zero
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr_i) |-> (hist_q == '0));
endmodule

// File: rtl/tag_resp_encoder.sv
module tag_resp_encoder
  import tre_pkg::*;
#(
  parameter int unsigned TS_W     = 16,
  parameter int unsigned LEN_W    = 6,
  parameter int unsigned SLOW_REP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] frame_len_i,
  input  logic [TS_W-1:0]  start_time_i,
  input  logic             slow_i,
  input  logic [TS_W-1:0]  tick_i,
  input  logic [7:0]       byte_i,
  input  logic             byte_valid_i,
  output logic             byte_ready_o,
  output logic             mod_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int unsigned REP_W = (SLOW_REP > 1) ? $clog2(SLOW_REP) : 1;
  localparam logic [REP_W-1:0] REP_SLOW_MAX = REP_W'(SLOW_REP - 1);
  localparam logic [GRP_W-1:0] TICK_LAST    = '1;

  tre_state_e        state_q, state_d;
  tre_seg_e          seg_q, seg_d;
  logic [GRP_W-1:0]  tick_q, tick_d;
  logic [REP_W-1:0]  rep_q, rep_d, rep_max;
  logic [3:0]        chip_q, chip_d;
  logic [LEN_W-1:0]  left_q, left_d;
  logic [LEN_W-1:0]  fetch_q, fetch_d;
  logic [7:0]        buf_q, buf_d, cur_q, cur_d;
  logic              buf_full_q, buf_full_d;
  logic [TS_W-1:0]   time_q, time_d;
  logic              slow_q, slow_d;
  logic              mod_q, mod_d;
  logic              ld_cur, chip_end, chip_val, dly_out, take;

  tre_chip_gen u_chip (
    .seg_i      (seg_q),
    .chip_idx_i (chip_q),
    .cur_byte_i (cur_q),
    .chip_o     (chip_val)
  );

  tre_delay #(.SEL_W(GRP_W)) u_delay (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (state_q == ST_WAIT),
    .en_i   ((state_q == ST_SEND) || (state_q == ST_FLUSH)),
    .din_i  ((state_q == ST_SEND) ? chip_val : 1'b0),
    .sel_i  (time_q[GRP_W-1:0]),
    .dout_o (dly_out)
  );

  assign rep_max      = slow_q ? REP_SLOW_MAX : '0;
  assign chip_end     = (tick_q == TICK_LAST) && (rep_q == rep_max);
  assign byte_ready_o = ((state_q == ST_WAIT) || (state_q == ST_SEND))
                        && !buf_full_q && (fetch_q != '0);
  assign take         = byte_ready_o && byte_valid_i;

  always_comb begin
    state_d    = state_q;
    seg_d      = seg_q;
    tick_d     = tick_q;
    rep_d      = rep_q;
    chip_d     = chip_q;
    left_d     = left_q;
    fetch_d    = fetch_q;
    buf_d      = buf_q;
    cur_d      = cur_q;
    buf_full_d = buf_full_q;
    time_d     = time_q;
    slow_d     = slow_q;
    ld_cur     = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d    = ST_WAIT;
          time_d     = start_time_i;
          slow_d     = slow_i;
          left_d     = frame_len_i;
          fetch_d    = frame_len_i;
          buf_full_d = 1'b0;
        end
      end
      ST_WAIT: begin
        tick_d = '0;
        rep_d  = '0;
        chip_d = '0;
        seg_d  = SEG_OPEN;
        if ((tick_i[TS_W-1:GRP_W] == time_q[TS_W-1:GRP_W]) &&
            (tick_i[GRP_W-1:0] == '0))
          state_d = ST_SEND;
      end
      ST_SEND: begin
        tick_d = tick_q + 1'b1;
        if (tick_q == TICK_LAST) rep_d = rep_q + 1'b1;
        if (chip_end) begin
          rep_d  = '0;
          chip_d = chip_q + 1'b1;
          unique case (seg_q)
            SEG_OPEN: if (chip_q == 4'd7) begin
              chip_d = '0;
              if (left_q == '0) seg_d = SEG_CLOSE;
              else begin
                seg_d  = SEG_DATA;
                ld_cur = 1'b1;
              end
            end
            SEG_DATA: if (chip_q == 4'd15) begin
              chip_d = '0;
              if (left_q == '0) seg_d = SEG_CLOSE;
              else              ld_cur = 1'b1;
            end
            SEG_CLOSE: if (chip_q == 4'd7) begin
              chip_d  = '0;
              state_d = ST_FLUSH;
            end
            default: seg_d = SEG_OPEN;
          endcase
        end
      end
      ST_FLUSH: begin
        tick_d = tick_q + 1'b1;
        if (tick_q == TICK_LAST) state_d = ST_DONE;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase

    if (ld_cur) begin
      cur_d      = buf_q;
      buf_full_d = 1'b0;
      left_d     = left_q - 1'b1;
    end
    if (take) begin
      buf_d      = byte_i;
      buf_full_d = 1'b1;
      fetch_d    = fetch_q - 1'b1;
    end
  end

  always_comb begin
    mod_d = 1'b0;
    if ((state_q == ST_SEND) || (state_q == ST_FLUSH)) mod_d = dly_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      seg_q      <= SEG_OPEN;
      tick_q     <= '0;
      rep_q      <= '0;
      chip_q     <= '0;
      left_q     <= '0;
      fetch_q    <= '0;
      buf_q      <= '0;
      cur_q      <= '0;
      buf_full_q <= 1'b0;
      time_q     <= '0;
      slow_q     <= 1'b0;
      mod_q      <= 1'b0;
    end else begin
      state_q    <= state_d;
      seg_q      <= seg_d;
      tick_q     <= tick_d;
      rep_q      <= rep_d;
      chip_q     <= chip_d;
      left_q     <= left_d;
      fetch_q    <= fetch_d;
      buf_q      <= buf_d;
      cur_q      <= cur_d;
      buf_full_q <= buf_full_d;
      time_q     <= time_d;
      slow_q     <= slow_d;
      mod_q      <= mod_d;
    end
  end

  assign mod_o  = mod_q;
  assign busy_o = (state_q != ST_IDLE);
  assign done_o = (state_q == ST_DONE);

  // R2: a chip value holds for all ticks of its chip period
  p_chip_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SEND && $past(state_q) == ST_SEND && tick_q != '0)
      |-> (chip_val == $past(chip_val)));

  // R6: sending begins only on the aligned start tick
  p_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SEND && $past(state_q) == ST_WAIT)
      |-> ($past(tick_i[TS_W-1:GRP_W]) == time_q[TS_W-1:GRP_W]
           && $past(tick_i[GRP_W-1:0]) == '0));

  // R8: no modulation outside a frame
  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mod_o);

  // R8: completion is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9: a strobe during a frame leaves the captured settings alone
  p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(time_q) && $stable(slow_q)));

  // R11: bytes are requested only while a frame is pending
  p_ready_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready_o |-> busy_o);
endmodule

// File: tb/sim_tag_resp_encoder.sv
module sim_tag_resp_encoder;
  localparam int CLK_P = 10;
  localparam int TS_W  = 16;
  localparam int LEN_W = 6;

  logic             clk;
  logic             rst_n;
  logic             start;
  logic [LEN_W-1:0] len;
  logic [TS_W-1:0]  st_time;
  logic             slow;
  logic [TS_W-1:0]  tick;
  logic [7:0]       byte_d;
  logic             byte_valid;
  logic             byte_ready, mod, busy, done;

  tag_resp_encoder #(.TS_W(TS_W), .LEN_W(LEN_W), .SLOW_REP(4)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .frame_len_i(len),
    .start_time_i(st_time), .slow_i(slow), .tick_i(tick),
    .byte_i(byte_d), .byte_valid_i(byte_valid), .byte_ready_o(byte_ready),
    .mod_o(mod), .busy_o(busy), .done_o(done)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] mem [64];
  int  ptr, nb;
  bit  active;
  int  base_t, dly, flen, end_t, cur_len;
  bit  cur_slow;
  bit  exp_bits [$];
  string exp_tags [$];
  int  wdog;

  assign byte_valid = (ptr < nb);
  assign byte_d     = mem[ptr[5:0]];

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  initial tick = '0;
  always @(posedge clk) tick <= tick + 1'b1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at tick %0d: actual %0d expected %0d", req, tick, act, exp);
    end
  endtask

  task automatic push_chip(input bit v, input string tag, input int rep);
    for (int t = 0; t < rep * 8; t++) begin
      exp_bits.push_back(v);
      exp_tags.push_back(tag);
    end
  endtask

  // reference: frame built from the requirements when a strobe is accepted
  always @(posedge clk) begin
    if (!rst_n) begin
      active = 1'b0;
      ptr <= 0;
      nb  <= 0;
    end else begin
      if (byte_valid && byte_ready) ptr <= ptr + 1;
      if (start && !active) begin
        automatic bit op [8] = '{0,0,0,1,1,1,0,1};
        automatic bit cl [8] = '{1,0,1,1,1,0,0,0};
        automatic int rep = slow ? 4 : 1;
        automatic string tf = (len == 0) ? "R10" : (slow ? "R5" : "R3");
        automatic string td = slow ? "R5" : "R4";
        exp_bits.delete();
        exp_tags.delete();
        for (int c = 0; c < 8; c++) push_chip(op[c], tf, rep);
        for (int i = 0; i < int'(len); i++)
          for (int b = 0; b < 8; b++) begin
            push_chip(!mem[i][b], td, rep);
            push_chip(mem[i][b], td, rep);
          end
        for (int c = 0; c < 8; c++) push_chip(cl[c], tf, rep);
        flen     = exp_bits.size();
        base_t   = int'(st_time) & ~7;
        dly      = int'(st_time) & 7;
        end_t    = base_t + 2 + flen + 7;
        cur_len  = int'(len);
        cur_slow = slow;
        active   = 1'b1;
        ptr <= 0;
        nb  <= int'(len);
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    wdog++;
    if (!rst_n) begin
      chk(mod == 0 && busy == 0 && done == 0 && byte_ready == 0, "R1",
          {mod, busy, done, byte_ready}, 0);
    end else begin
      automatic int v = int'(tick);
      automatic bit emod = 1'b0;
      automatic string tag = "R8";
      if (active) begin
        automatic int k = v - (base_t + 2);
        if (k >= 0 && k < dly) tag = "R6";
        else if (k >= dly && k - dly < flen) begin
          emod = exp_bits[k - dly];
          tag  = exp_tags[k - dly];
        end else if (k >= dly + flen) tag = "R7";
      end
      chk(mod == emod, tag, mod, emod);
      chk(busy == active, "R8", busy, active);
      chk(done == (active && v == end_t), "R8", done, active && v == end_t);
      chk(!(byte_ready && !busy), "R11", byte_ready, 0);
      if (active && v == end_t) active = 1'b0;
    end
  end

  task automatic run_frame(input int n, input bit s, input int d, input bit poke);
    for (int i = 0; i < n; i++) mem[i] = 8'(i * 37 + n * 11 + d) ^ 8'h5A;
    @(negedge clk);
    st_time = TS_W'(((int'(tick) + 16) & ~7) | d);
    len     = LEN_W'(n);
    slow    = s;
    start   = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R9: strobe mid-frame with different settings
      repeat (100) @(negedge clk);
      st_time = tick + 16'd40;
      len     = 6'd5;
      slow    = !s;
      start   = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (active) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(ptr == n, "R11", ptr, n);
    chk(!busy, "R9", busy, 0);
  endtask

  initial begin
    wdog    = 0;
    rst_n   = 1'b0;
    start   = 1'b0;
    len     = '0;
    st_time = '0;
    slow    = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run_frame(2, 1'b0, 0, 1'b0);
    run_frame(3, 1'b0, 5, 1'b1);
    run_frame(2, 1'b1, 3, 1'b0);
    run_frame(0, 1'b0, 7, 1'b0);
    run_frame(1, 1'b1, 0, 1'b0);
    run_frame(4, 1'b0, 1, 1'b0);
    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    while (wdog < 100000) @(negedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", wdog);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule